// File: doc/BRIEF.md
# Delay-Line Converter Linearity Calibrator

This block sits behind the sampling flip-flops of a delay-line time-to-digital converter. Each sample arrives as a vector of flip-flop states. The block turns the vector into a raw code by counting its ones, and never by finding the first transition. A bubble (one misplaced bit) therefore shifts the code by at most what the bit itself is worth, and the code stays monotonic.

In calibration mode the block raises a select output. Outside logic uses that output to switch the converter's two timing inputs to a pair of free-running clocks that are not related to each other. The raw codes that result are collected into a histogram of saturating bins until a programmed total of 2^M samples has arrived. The block then walks the bins once, one per clock, and builds a correction table from the running sum at each bin midpoint.

In normal mode every raw code goes through that table, so each output step matches the real time width of its code. Until a table has been completed, the raw code goes out unchanged.

Top module: `tdc_lin_cal`

## Requirements
- R1: The raw code of a sample is the number of ones in `smp_vec`, whatever their positions, so its range is 0 to NDFF. Example: 32'h0000000B gives 3.
- R2: In normal mode (`cal_mode`=0), a sample presented with `smp_valid` on clock edge n gives `out_valid`=1 with its code after edge n+1, and `out_valid` is 0 after edge n alone.
- R3: While `cal_done` is 0, `out_code` in normal mode equals the raw code, zero-extended.
- R4: `osc_select` equals `cal_mode` one edge later and resets to 0. Samples taken with `cal_mode`=1 never raise `out_valid`.
- R5: A one-cycle `cal_start` clears every histogram bin, clears `cal_done` on the following edge, and opens collection of exactly 2^`log2_total` calibration-mode samples.
- R6: A histogram bin stops at 2^HIST_W-1 and never wraps.
- R7: After the last counted sample, the table is built one bin per clock and `cal_done` is set. Entry k is floor((2·C(k-1)+H(k))·FS / 2^(M+1)), where H is the bin count, C is the running sum of H with C(-1)=0, M=`log2_total` and FS=2^OUT_W-1.
- R8: While `cal_done` is 1, `out_code` in normal mode equals table entry k for raw code k.
- R9: Samples that arrive after collection ends do not change the table, and `cal_done` stays 1 until the next `cal_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_mode | input | 1 | 1: calibration mode, 0: normal measurement |
| cal_start | input | 1 | One-cycle pulse that starts a calibration run |
| log2_total | input | LOGW | M, the log2 of the number of samples to collect |
| smp_valid | input | 1 | smp_vec holds a new sample |
| smp_vec | input | NDFF | Sampled flip-flop states |
| osc_select | output | 1 | Selects the free-running clock pair for the timing inputs |
| out_valid | output | 1 | out_code holds a normal-mode result |
| out_code | output | OUT_W | Corrected (or raw) output code |
| cal_done | output | 1 | Correction table is valid |

## Verification
The ones counter is tried with solid thermometer vectors, vectors with a bubble, sparse and alternating patterns, and the all-zero and all-one extremes. These separate a true population count from a first-edge encoder and show that the range ends are reached. The first calibration uses a deliberately uneven code spread, with one dominant code, followed by extra samples after collection ends. Reading back every code through the table then separates the midpoint cumulative formula from off-by-one or non-midpoint variants, and shows whether late samples leaked into the histogram. A second run piles more samples than a bin can hold into one code. That tells saturation from wrap-around, and a cleared histogram from one that still holds counts from the first run.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_BUILD = 2'd2
    } cal_state_e;
endpackage

// File: rtl/tdc_ones_count.sv
module tdc_ones_count #(
    parameter int NDFF   = 32,
    parameter int CODE_W = $clog2(NDFF + 1)
) (
    input  logic [NDFF-1:0]   vec,
    output logic [CODE_W-1:0] code
);
    // Population count: position-independent, so bubbles cannot reorder codes
    always_comb begin
        code = '0;
        for (int i = 0; i < NDFF; i++) begin
            code = code + CODE_W'(vec[i]);
        end
    end
endmodule

// File: rtl/tdc_hist_bank.sv
module tdc_hist_bank #(
    parameter int NBINS  = 33,
    parameter int HIST_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [IDX_W-1:0]  inc_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_data
);
    localparam logic [HIST_W-1:0] BIN_MAX = '1;

    logic [HIST_W-1:0] bin_d [NBINS];
    logic [HIST_W-1:0] bin_q [NBINS];

    always_comb begin
        bin_d = bin_q;
        if (clr) begin
            for (int b = 0; b < NBINS; b++) bin_d[b] = '0;
        end else if (inc) begin
            for (int b = 0; b < NBINS; b++) begin
                if (inc_idx == IDX_W'(b) && bin_q[b] != BIN_MAX) begin
                    bin_d[b] = bin_q[b] + HIST_W'(1);
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBINS; b++) begin
            if (rd_idx == IDX_W'(b)) rd_data = bin_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBINS; b++) bin_q[b] <= '0;
        end else begin
            bin_q <= bin_d;
        end
    end

    // R6: a bin only grows until cleared; it never wraps back down
    for (genvar g = 0; g < NBINS; g++) begin : g_bin_chk
        a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> bin_q[g] >= $past(bin_q[g]));
    end
    // R5: a clear empties the bin that is read back
    a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> rd_data == '0);
endmodule

// File: rtl/tdc_cal_ctrl.sv
module tdc_cal_ctrl
    import tdc_cal_pkg::*;
#(
    parameter int NBINS  = 33,
    parameter int HIST_W = 16,
    parameter int OUT_W  = 8,
    parameter int LOGW   = 5,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              smp_cal,
    input  logic [LOGW-1:0]   log2_total,
    input  logic [HIST_W-1:0] hist_rd_data,
    output logic              hist_clr,
    output logic              hist_inc,
    output logic [IDX_W-1:0]  hist_rd_idx,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [OUT_W-1:0]  tbl_val,
    output logic              cal_done
);
    localparam int CNT_W  = 2 ** LOGW;
    localparam int CUM_W  = HIST_W + IDX_W + 1;
    localparam int PROD_W = CUM_W + 1 + OUT_W;
    localparam logic [PROD_W-1:0] FULLSCALE = PROD_W'((2 ** OUT_W) - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NBINS - 1);

    typedef struct packed {
        cal_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [CUM_W-1:0] cum;
        logic             done;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [CNT_W-1:0]  last_cnt;
    logic [PROD_W-1:0] num;
    logic [LOGW:0]     shamt;

    always_comb begin
        last_cnt = (CNT_W'(1) << log2_total) - CNT_W'(1);
        shamt    = {1'b0, log2_total} + (LOGW + 1)'(1);
        num      = (PROD_W'({c_q.cum, 1'b0}) + PROD_W'(hist_rd_data)) * FULLSCALE;

        c_d         = c_q;
        hist_clr    = 1'b0;
        hist_inc    = 1'b0;
        hist_rd_idx = c_q.idx;
        tbl_we      = 1'b0;
        tbl_idx     = c_q.idx;
        tbl_val     = OUT_W'(num >> shamt);

        if (cal_start) begin
            hist_clr = 1'b1;
            c_d.st   = ST_ACCUM;
            c_d.cnt  = '0;
            c_d.done = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_ACCUM: begin
                    if (smp_cal) begin
                        hist_inc = 1'b1;
                        c_d.cnt  = c_q.cnt + CNT_W'(1);
                        if (c_q.cnt == last_cnt) begin
                            c_d.st  = ST_BUILD;
                            c_d.idx = '0;
                            c_d.cum = '0;
                        end
                    end
                end
                ST_BUILD: begin
                    tbl_we  = 1'b1;
                    c_d.cum = c_q.cum + CUM_W'(hist_rd_data);
                    c_d.idx = c_q.idx + IDX_W'(1);
                    if (c_q.idx == LAST_IDX) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, cnt: '0, idx: '0, cum: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign cal_done = c_q.done;

    // R7: the table becomes valid only straight out of the build walk
    a_r7_done_after_build: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(c_q.st) == ST_BUILD);
    // R5: a start pulse withdraws the table
    a_r5_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_done);
    // R7: the build walk never writes while a valid table is reported
    a_r7_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !tbl_we);
endmodule

// File: rtl/tdc_code_map.sv
module tdc_code_map #(
    parameter int NBINS = 33,
    parameter int OUT_W = 8,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OUT_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [OUT_W-1:0] rd_val
);
    logic [OUT_W-1:0] ent_d [NBINS];
    logic [OUT_W-1:0] ent_q [NBINS];

    always_comb begin
        ent_d = ent_q;
        for (int k = 0; k < NBINS; k++) begin
            if (we && wr_idx == IDX_W'(k)) ent_d[k] = wr_val;
        end
        rd_val = '0;
        for (int k = 0; k < NBINS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_val = ent_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NBINS; k++) ent_q[k] <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end
endmodule

// File: rtl/tdc_lin_cal.sv
module tdc_lin_cal #(
    parameter int NDFF   = 32,
    parameter int OUT_W  = 8,
    parameter int HIST_W = 16,
    parameter int LOGW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_mode,
    input  logic             cal_start,
    input  logic [LOGW-1:0]  log2_total,
    input  logic             smp_valid,
    input  logic [NDFF-1:0]  smp_vec,
    output logic             osc_select,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code,
    output logic             cal_done
);
    localparam int CODE_W = $clog2(NDFF + 1);
    localparam int NBINS  = NDFF + 1;
    localparam int IDX_W  = CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] raw;
        logic              raw_vld;
        logic              mode;
        logic [OUT_W-1:0]  code;
        logic              code_vld;
    } pipe_t;

    pipe_t p_d, p_q;

    logic [CODE_W-1:0] cnt_code;
    logic [HIST_W-1:0] hist_rd_data;
    logic              hist_clr, hist_inc;
    logic [IDX_W-1:0]  hist_rd_idx;
    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_idx;
    logic [OUT_W-1:0]  tbl_val;
    logic [OUT_W-1:0]  mapped;
    logic              smp_cal;

    tdc_ones_count #(.NDFF(NDFF), .CODE_W(CODE_W)) u_ones (
        .vec  (smp_vec),
        .code (cnt_code)
    );

    assign smp_cal = p_q.raw_vld && p_q.mode;

    tdc_hist_bank #(.NBINS(NBINS), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hist_clr),
        .inc     (hist_inc),
        .inc_idx (p_q.raw),
        .rd_idx  (hist_rd_idx),
        .rd_data (hist_rd_data)
    );

    tdc_cal_ctrl #(
        .NBINS(NBINS), .HIST_W(HIST_W), .OUT_W(OUT_W), .LOGW(LOGW), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_start    (cal_start),
        .smp_cal      (smp_cal),
        .log2_total   (log2_total),
        .hist_rd_data (hist_rd_data),
        .hist_clr     (hist_clr),
        .hist_inc     (hist_inc),
        .hist_rd_idx  (hist_rd_idx),
        .tbl_we       (tbl_we),
        .tbl_idx      (tbl_idx),
        .tbl_val      (tbl_val),
        .cal_done     (cal_done)
    );

    tdc_code_map #(.NBINS(NBINS), .OUT_W(OUT_W), .IDX_W(IDX_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .wr_idx (tbl_idx),
        .wr_val (tbl_val),
        .rd_idx (p_q.raw),
        .rd_val (mapped)
    );

    always_comb begin
        p_d          = p_q;
        p_d.raw      = cnt_code;
        p_d.raw_vld  = smp_valid;
        p_d.mode     = cal_mode;
        p_d.code_vld = p_q.raw_vld && !p_q.mode;
        if (p_q.raw_vld && !p_q.mode) begin
            p_d.code = cal_done ? mapped : OUT_W'(p_q.raw);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign osc_select = p_q.mode;
    assign out_valid  = p_q.code_vld;
    assign out_code   = p_q.code;

    // R1: a registered raw code never leaves the 0..NDFF range
    a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.raw_vld |-> p_q.raw <= CODE_W'(NDFF));
    // R4: calibration-mode samples never reach the output
    a_r4_no_out_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$past(p_q.mode) && $past(p_q.raw_vld));
    // R3: without a table the raw code passes unchanged
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(cal_done)) |-> out_code == OUT_W'($past(p_q.raw)));
endmodule

// File: tb/tb_tdc_lin_cal.sv
module tb_tdc_lin_cal;
    localparam int NDFF   = 32;
    localparam int OUT_W  = 8;
    localparam int HIST_W = 6;
    localparam int LOGW   = 5;
    localparam int NBINS  = NDFF + 1;
    localparam int NVEC   = 11;

    localparam logic [NDFF-1:0] VEC [NVEC] = '{
        32'h00000000, 32'hFFFFFFFF, 32'h00000001, 32'h0000000F, 32'h0000000B,
        32'h0000002F, 32'h80000000, 32'h0000FFFF, 32'h0001FF7F, 32'hAAAAAAAA,
        32'hFFFFFFFE };
    localparam int VEXP [NVEC] = '{0, 32, 1, 4, 3, 5, 1, 16, 16, 16, 31};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_mode = 1'b0;
    logic cal_start = 1'b0;
    logic [LOGW-1:0] log2_total = '0;
    logic smp_valid = 1'b0;
    logic [NDFF-1:0] smp_vec = '0;
    logic osc_select, out_valid, cal_done;
    logic [OUT_W-1:0] out_code;

    int n_chk = 0;
    int n_fail = 0;
    int hist [NBINS];
    int exp_tbl [NBINS];

    always #4 clk = ~clk;

    tdc_lin_cal #(.NDFF(NDFF), .OUT_W(OUT_W), .HIST_W(HIST_W), .LOGW(LOGW)) dut (
        .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .cal_start(cal_start),
        .log2_total(log2_total), .smp_valid(smp_valid), .smp_vec(smp_vec),
        .osc_select(osc_select), .out_valid(out_valid), .out_code(out_code),
        .cal_done(cal_done));

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // n ones with a bubble: swap bit n-2 (set) and bit n (clear)
    function automatic logic [NDFF-1:0] bubbly(input int n);
        logic [NDFF-1:0] v = '0;
        for (int i = 0; i < n; i++) v[i] = 1'b1;
        if (n >= 2 && n < NDFF) begin
            v[n-2] = 1'b0;
            v[n]   = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [NDFF-1:0] thermo(input int n);
        logic [NDFF-1:0] v = '0;
        for (int i = 0; i < n; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic build_expected(input int m);
        longint c = 0;
        longint fs = (1 << OUT_W) - 1;
        for (int k = 0; k < NBINS; k++) begin
            int h = (hist[k] > (1 << HIST_W) - 1) ? (1 << HIST_W) - 1 : hist[k];
            exp_tbl[k] = int'(((2 * c + h) * fs) >> (m + 1));
            c += h;
        end
    endtask

    // One normal-mode sample; checks latency and returned code
    task automatic measure(input logic [NDFF-1:0] v, input int exp, input string req);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_vec   = v;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(int'(out_valid), 0, "R2 latency");
        @(negedge clk);
        chk(int'(out_valid), 1, "R2 valid");
        chk(int'(out_code), exp, req);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!cal_done && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk(int'(cal_done), 1, "R7 done");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seen_valid;
        repeat (3) @(negedge clk);
        chk(int'(out_valid), 0, "R2 reset");
        chk(int'(cal_done), 0, "R3 reset");
        chk(int'(osc_select), 0, "R4 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: ones counting and passthrough before calibration
        for (int i = 0; i < NVEC; i++) measure(VEC[i], VEXP[i], "R1 R3 count");
        measure(bubbly(9), 9, "R1 bubble");

        // First calibration: uneven spread, 2^6 samples
        cal_mode = 1'b1;
        @(negedge clk);
        chk(int'(osc_select), 1, "R4 select");
        log2_total = LOGW'(6);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk(int'(cal_done), 0, "R5 start");
        for (int k = 0; k < NBINS; k++) hist[k] = 0;
        seen_valid = 0;
        for (int i = 0; i < 64; i++) begin
            int code = (i < 40) ? (i * 7) % 33 : 3;
            hist[code]++;
            smp_valid = 1'b1;
            smp_vec   = bubbly(code);
            @(negedge clk);
            seen_valid |= int'(out_valid);
        end
        // Late samples: must not be counted (R9)
        for (int i = 0; i < 5; i++) begin
            smp_vec = '0;
            @(negedge clk);
            seen_valid |= int'(out_valid);
        end
        smp_valid = 1'b0;
        @(negedge clk);
        seen_valid |= int'(out_valid);
        chk(seen_valid, 0, "R4 no output in cal mode");
        wait_done();
        build_expected(6);
        cal_mode = 1'b0;
        @(negedge clk);
        chk(int'(osc_select), 0, "R4 select back");
        for (int k = 0; k < NBINS; k++) measure(thermo(k), exp_tbl[k], "R8 R9 table");
        chk(int'(cal_done), 1, "R9 done held");

        // Second calibration: saturation, and clearing of earlier counts
        cal_mode = 1'b1;
        log2_total = LOGW'(7);
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk(int'(cal_done), 0, "R5 restart");
        for (int k = 0; k < NBINS; k++) hist[k] = 0;
        for (int i = 0; i < 128; i++) begin
            hist[5]++;
            smp_valid = 1'b1;
            smp_vec   = bubbly(5);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        wait_done();
        build_expected(7);
        cal_mode = 1'b0;
        @(negedge clk);
        measure(thermo(4), exp_tbl[4], "R5 clear");
        chk(exp_tbl[5], 62, "R6 expected model");
        measure(thermo(5), exp_tbl[5], "R6 saturate");
        measure(thermo(20), exp_tbl[20], "R6 R7 above");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule